// File: doc/BRIEF.md
# Ring-Counter Control Sequencer for an Accumulator Machine

This block is the control unit of a small shared-bus accumulator computer. A one-hot timing ring steps through six states for every instruction. The first three states fetch an instruction and the last three execute it. In each state the block decodes the current ring position and the 4-bit opcode held in the instruction register. From that decode it drives a control word. The control word selects which register may drive the shared bus, which registers load from it, whether the program counter advances, the add/subtract selection and the halt line.

The control outputs are a fixed mix of active-low and active-high lines. They are decoded combinationally from the registered ring and opcode, so every line changes in the same cycle as the ring state it belongs to.

A halt instruction stops the ring in its first execute state. From then on the block asserts only the halt line until the next reset. Any opcode other than the five defined ones leaves the three execute states idle.

Top module: `ctl_ring_sequencer`

## Requirements
- R1: While `rst` is high, every control output sits at its inactive level: `pc_inc`, `pc_drive`, `acc_drive`, `alu_sub` and `alu_drive` are 0, and `mar_load_n`, `mem_drive_n`, `ir_load_n`, `ir_drive_n`, `acc_load_n`, `breg_load_n`, `outreg_load_n` and `halt_n` are 1. The clock edge taken with `rst` high sets `t_state` to 6'b000001 (T1).
- R2: `t_state` is one-hot, with bit k standing for state T(k+1). When not halted, each clock edge moves it one position, T1 through T6, and from T6 back to T1.
- R3: The fetch states do not depend on the opcode. In T1, `pc_drive` is 1 and `mar_load_n` is 0. In T2, only `pc_inc` is active. In T3, `mem_drive_n` and `ir_load_n` are 0. No other line is active in these states.
- R4: For opcode 4'b0000 (load): T4 asserts `ir_drive_n`=0 and `mar_load_n`=0, and T5 asserts `mem_drive_n`=0 and `acc_load_n`=0. T6 is idle.
- R5: For opcodes 4'b0001 (add) and 4'b0010 (subtract): T4 matches the load case and T5 asserts `mem_drive_n`=0 and `breg_load_n`=0. T6 asserts `alu_drive`=1 and `acc_load_n`=0. `alu_sub` is 1 only in T6 of opcode 4'b0010 and is 0 everywhere else.
- R6: For opcode 4'b1110 (output), T4 asserts `acc_drive`=1 and `outreg_load_n`=0. T5 and T6 are idle.
- R7: For opcode 4'b1111 (halt), T4 drives `halt_n`=0 and nothing else. The ring then stays at T4 with only `halt_n` low, whatever the opcode does afterwards, until `rst` is asserted.
- R8: Any opcode other than the five above leaves T4, T5 and T6 idle, and the ring keeps cycling.
- R9: In every cycle at most one bus source is enabled. The bus sources are `pc_drive`, `mem_drive_n` low, `ir_drive_n` low, `acc_drive` and `alu_drive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Opcode field from the instruction register |
| t_state | output | 6 | One-hot timing state, bit 0 = T1 |
| pc_inc | output | 1 | Program counter increment, active high |
| pc_drive | output | 1 | Program counter drives bus, active high |
| mar_load_n | output | 1 | Memory address register load, active low |
| mem_drive_n | output | 1 | Memory drives bus, active low |
| ir_load_n | output | 1 | Instruction register load, active low |
| ir_drive_n | output | 1 | Instruction register address field drives bus, active low |
| acc_load_n | output | 1 | Accumulator load, active low |
| acc_drive | output | 1 | Accumulator drives bus, active high |
| alu_sub | output | 1 | Adder-subtractor selects subtract, active high |
| alu_drive | output | 1 | Adder-subtractor drives bus, active high |
| breg_load_n | output | 1 | B register load, active low |
| outreg_load_n | output | 1 | Output register load, active low |
| halt_n | output | 1 | Halt, active low |

## Verification
The bench builds the block with its package defaults: a six-state ring, three fetch states and 4-bit opcodes. With these values every state of every defined opcode, plus one undefined opcode, can be reached within a few cycles after reset, so the full control word is compared in all 30 state/opcode pairs. On top of that run, the bench checks the return from T6 to T1, the freeze on halt while the opcode changes underneath, and a reset taken in the middle of an instruction.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

  localparam int OPC_W     = 4;
  localparam int T_STATES  = 6;
  localparam int FETCH_LEN = 3;
  localparam int EXEC_LEN  = T_STATES - FETCH_LEN;
  localparam int STOP_IDX  = FETCH_LEN;   // first execute state

  localparam logic [OPC_W-1:0] OPC_LOAD = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_SUB  = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_SHOW = 4'b1110;
  localparam logic [OPC_W-1:0] OPC_STOP = 4'b1111;

  // Internal control word, every field active high.
  typedef struct packed {
    logic pc_inc;
    logic pc_drive;
    logic mar_ld;
    logic mem_drive;
    logic ir_ld;
    logic ir_drive;
    logic acc_ld;
    logic acc_drive;
    logic alu_sub;
    logic alu_drive;
    logic b_ld;
    logic out_ld;
    logic halt;
  } ctl_word_t;

  localparam int CW_W = $bits(ctl_word_t);

  localparam ctl_word_t CW_IDLE = '0;

  // Pin polarity: 1 marks a line that is driven active low.
  localparam ctl_word_t CW_ACT_LOW = '{
    pc_inc:    1'b0,
    pc_drive:  1'b0,
    mar_ld:    1'b1,
    mem_drive: 1'b1,
    ir_ld:     1'b1,
    ir_drive:  1'b1,
    acc_ld:    1'b1,
    acc_drive: 1'b0,
    alu_sub:   1'b0,
    alu_drive: 1'b0,
    b_ld:      1'b1,
    out_ld:    1'b1,
    halt:      1'b1
  };

endpackage

// File: rtl/ctl_timing_ring.sv
module ctl_timing_ring #(
  parameter int LEN = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stop_req,
  output logic [LEN-1:0] ring,
  output logic           frozen
);

  localparam logic [LEN-1:0] RING_INIT = LEN'(1);

  logic advance;
  assign advance = !(stop_req || frozen);

  always_ff @(posedge clk) begin
    if (rst) begin
      ring   <= RING_INIT;
      frozen <= 1'b0;
    end else begin
      if (stop_req) begin
        frozen <= 1'b1;
      end
      if (advance) begin
        ring <= {ring[LEN-2:0], ring[LEN-1]};
      end
    end
  end

endmodule

// File: rtl/ctl_word_decode.sv
module ctl_word_decode
  import ctl_seq_pkg::*;
(
  input  logic [T_STATES-1:0] ring,
  input  logic [OPC_W-1:0]    opcode,
  input  logic                frozen,
  output ctl_word_t           word,
  output logic                stop_req
);

  function automatic ctl_word_t fetch_word(input int step);
    ctl_word_t w;
    w = CW_IDLE;
    case (step)
      0: begin
        w.pc_drive = 1'b1;
        w.mar_ld   = 1'b1;
      end
      1: w.pc_inc = 1'b1;
      2: begin
        w.mem_drive = 1'b1;
        w.ir_ld     = 1'b1;
      end
      default: w = CW_IDLE;
    endcase
    return w;
  endfunction

  function automatic ctl_word_t exec_word(input logic [OPC_W-1:0] op, input int step);
    ctl_word_t w;
    w = CW_IDLE;
    case (op)
      OPC_LOAD: begin
        if (step == 0) begin
          w.ir_drive = 1'b1;
          w.mar_ld   = 1'b1;
        end else if (step == 1) begin
          w.mem_drive = 1'b1;
          w.acc_ld    = 1'b1;
        end
      end
      OPC_ADD, OPC_SUB: begin
        if (step == 0) begin
          w.ir_drive = 1'b1;
          w.mar_ld   = 1'b1;
        end else if (step == 1) begin
          w.mem_drive = 1'b1;
          w.b_ld      = 1'b1;
        end else if (step == 2) begin
          w.alu_drive = 1'b1;
          w.acc_ld    = 1'b1;
          w.alu_sub   = (op == OPC_SUB);
        end
      end
      OPC_SHOW: begin
        if (step == 0) begin
          w.acc_drive = 1'b1;
          w.out_ld    = 1'b1;
        end
      end
      OPC_STOP: begin
        if (step == 0) begin
          w.halt = 1'b1;
        end
      end
      default: w = CW_IDLE;
    endcase
    return w;
  endfunction

  always_comb begin
    word     = CW_IDLE;
    stop_req = 1'b0;
    if (frozen) begin
      word.halt = 1'b1;
    end else begin
      for (int i = 0; i < T_STATES; i++) begin
        if (ring[i]) begin
          word = (i < FETCH_LEN) ? fetch_word(i) : exec_word(opcode, i - FETCH_LEN);
        end
      end
      stop_req = ring[STOP_IDX] && (opcode == OPC_STOP);
    end
  end

endmodule

// File: rtl/ctl_drive_stage.sv
module ctl_drive_stage #(
  parameter int           W        = 13,
  parameter logic [W-1:0] LOW_MASK = '0
) (
  input  logic         rst,
  input  logic [W-1:0] act,
  output logic [W-1:0] pins
);

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_line
      if (LOW_MASK[gi]) begin : g_low
        assign pins[gi] = ~(act[gi] & ~rst);
      end else begin : g_high
        assign pins[gi] = act[gi] & ~rst;
      end
    end
  endgenerate

endmodule

// File: rtl/ctl_ring_sequencer.sv
module ctl_ring_sequencer
  import ctl_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [OPC_W-1:0]    opcode,
  output logic [T_STATES-1:0] t_state,
  output logic                pc_inc,
  output logic                pc_drive,
  output logic                mar_load_n,
  output logic                mem_drive_n,
  output logic                ir_load_n,
  output logic                ir_drive_n,
  output logic                acc_load_n,
  output logic                acc_drive,
  output logic                alu_sub,
  output logic                alu_drive,
  output logic                breg_load_n,
  output logic                outreg_load_n,
  output logic                halt_n
);

  logic      stop_req;
  logic      frozen;
  ctl_word_t word;
  ctl_word_t pin_w;
  logic [CW_W-1:0] pin_bits;

  ctl_timing_ring #(
    .LEN (T_STATES)
  ) u_ring (
    .clk      (clk),
    .rst      (rst),
    .stop_req (stop_req),
    .ring     (t_state),
    .frozen   (frozen)
  );

  ctl_word_decode u_decode (
    .ring     (t_state),
    .opcode   (opcode),
    .frozen   (frozen),
    .word     (word),
    .stop_req (stop_req)
  );

  ctl_drive_stage #(
    .W        (CW_W),
    .LOW_MASK (CW_ACT_LOW)
  ) u_drive (
    .rst  (rst),
    .act  (word),
    .pins (pin_bits)
  );

  assign pin_w = ctl_word_t'(pin_bits);

  assign pc_inc        = pin_w.pc_inc;
  assign pc_drive      = pin_w.pc_drive;
  assign mar_load_n    = pin_w.mar_ld;
  assign mem_drive_n   = pin_w.mem_drive;
  assign ir_load_n     = pin_w.ir_ld;
  assign ir_drive_n    = pin_w.ir_drive;
  assign acc_load_n    = pin_w.acc_ld;
  assign acc_drive     = pin_w.acc_drive;
  assign alu_sub       = pin_w.alu_sub;
  assign alu_drive     = pin_w.alu_drive;
  assign breg_load_n   = pin_w.b_ld;
  assign outreg_load_n = pin_w.out_ld;
  assign halt_n        = pin_w.halt;

endmodule

// File: rtl/ctl_ring_sequencer_chk.sv
module ctl_ring_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] opcode,
  input logic [5:0] t_state,
  input logic       pc_inc,
  input logic       pc_drive,
  input logic       mar_load_n,
  input logic       mem_drive_n,
  input logic       ir_load_n,
  input logic       ir_drive_n,
  input logic       acc_load_n,
  input logic       acc_drive,
  input logic       alu_sub,
  input logic       alu_drive,
  input logic       breg_load_n,
  input logic       outreg_load_n,
  input logic       halt_n
);

  // R1: inactive levels while reset is held
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |-> (!pc_inc && !pc_drive && !acc_drive && !alu_sub && !alu_drive &&
             mar_load_n && mem_drive_n && ir_load_n && ir_drive_n &&
             acc_load_n && breg_load_n && outreg_load_n && halt_n));

  // R2: ring stays one-hot
  assert_ring_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(t_state) == 1);

  // R2: ring rotates when not halting
  assert_ring_step_R2: assert property (@(posedge clk) disable iff (rst)
    (halt_n && !(t_state[3] && opcode == 4'b1111))
    |=> t_state == {$past(t_state[4:0]), $past(t_state[5])});

  // R3: first fetch state addresses memory from the program counter
  assert_fetch_addr_R3: assert property (@(posedge clk) disable iff (rst)
    t_state[0] |-> (pc_drive && !mar_load_n && !pc_inc));

  // R5: subtract select only for the subtract opcode
  assert_sub_only_R5: assert property (@(posedge clk) disable iff (rst)
    alu_sub |-> (opcode == 4'b0010 && t_state[5]));

  // R7: halt freezes the ring at T4
  assert_halt_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (t_state[3] && opcode == 4'b1111) |=> (t_state == 6'b001000 && !halt_n));

  // R7: halt is sticky until reset
  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !halt_n |=> (!halt_n && $stable(t_state)));

  // R9: single bus source
  assert_one_source_R9: assert property (@(posedge clk) disable iff (rst)
    $countones({pc_drive, !mem_drive_n, !ir_drive_n, acc_drive, alu_drive}) <= 1);

endmodule

bind ctl_ring_sequencer ctl_ring_sequencer_chk i_chk (
  .clk           (clk),
  .rst           (rst),
  .opcode        (opcode),
  .t_state       (t_state),
  .pc_inc        (pc_inc),
  .pc_drive      (pc_drive),
  .mar_load_n    (mar_load_n),
  .mem_drive_n   (mem_drive_n),
  .ir_load_n     (ir_load_n),
  .ir_drive_n    (ir_drive_n),
  .acc_load_n    (acc_load_n),
  .acc_drive     (acc_drive),
  .alu_sub       (alu_sub),
  .alu_drive     (alu_drive),
  .breg_load_n   (breg_load_n),
  .outreg_load_n (outreg_load_n),
  .halt_n        (halt_n)
);

// File: tb/test_ctl_ring_sequencer.sv
`timescale 1ns/100ps
module test_ctl_ring_sequencer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opcode = 4'h0;
  logic [5:0] t_state;
  logic pc_inc, pc_drive, mar_load_n, mem_drive_n, ir_load_n, ir_drive_n;
  logic acc_load_n, acc_drive, alu_sub, alu_drive, breg_load_n, outreg_load_n, halt_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ctl_ring_sequencer i_ctl_ring_sequencer (
    .clk(clk), .rst(rst), .opcode(opcode), .t_state(t_state),
    .pc_inc(pc_inc), .pc_drive(pc_drive), .mar_load_n(mar_load_n),
    .mem_drive_n(mem_drive_n), .ir_load_n(ir_load_n), .ir_drive_n(ir_drive_n),
    .acc_load_n(acc_load_n), .acc_drive(acc_drive), .alu_sub(alu_sub),
    .alu_drive(alu_drive), .breg_load_n(breg_load_n),
    .outreg_load_n(outreg_load_n), .halt_n(halt_n)
  );

  // Active-high view, bit 12..0:
  // pc_inc pc_drive mar mem_drive ir_ld ir_drive acc_ld acc_drive alu_sub alu_drive b_ld out_ld halt
  localparam logic [12:0] W_T1   = 13'h0C00;
  localparam logic [12:0] W_T2   = 13'h1000;
  localparam logic [12:0] W_T3   = 13'h0300;
  localparam logic [12:0] W_HALT = 13'h0001;

  localparam logic [3:0] OPS [5] = '{4'h0, 4'h1, 4'h2, 4'hE, 4'h5};
  localparam logic [12:0] EXP [30] = '{
    W_T1, W_T2, W_T3, 13'h0480, 13'h0240, 13'h0000,   // load
    W_T1, W_T2, W_T3, 13'h0480, 13'h0204, 13'h0048,   // add
    W_T1, W_T2, W_T3, 13'h0480, 13'h0204, 13'h0058,   // subtract
    W_T1, W_T2, W_T3, 13'h0022, 13'h0000, 13'h0000,   // output
    W_T1, W_T2, W_T3, 13'h0000, 13'h0000, 13'h0000    // undefined
  };
  localparam string TAGS [5] = '{"R4", "R5", "R5", "R6", "R8"};

  function automatic logic [12:0] obs();
    return {pc_inc, pc_drive, ~mar_load_n, ~mem_drive_n, ~ir_load_n, ~ir_drive_n,
            ~acc_load_n, acc_drive, alu_sub, alu_drive, ~breg_load_n,
            ~outreg_load_n, ~halt_n};
  endfunction

  function automatic int bus_count();
    return int'(pc_drive) + int'(~mem_drive_n) + int'(~ir_drive_n) +
           int'(acc_drive) + int'(alu_drive);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_idle_pins(input string tag);
    chk(tag, {27'd0, pc_inc, pc_drive, acc_drive, alu_sub, alu_drive}, 32'd0);
    chk(tag, {24'd0, mar_load_n, mem_drive_n, ir_load_n, ir_drive_n,
              acc_load_n, breg_load_n, outreg_load_n, halt_n}, 32'hFF);
  endtask

  task automatic hold_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    check_idle_pins("R1 reset pins");
    chk("R1 reset state", {26'd0, t_state}, 32'h1);
  endtask

  task automatic sample(input string tag, input int s, input logic [12:0] exp);
    chk({tag, " state"}, {26'd0, t_state}, 32'd1 << s);
    chk({tag, " word"}, {19'd0, obs()}, {19'd0, exp});
    chk("R9 bus sources", (bus_count() <= 1) ? 32'd1 : 32'd0, 32'd1);
  endtask

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    // Table walk over every state of each opcode
    for (int r = 0; r < 5; r++) begin
      hold_reset();
      opcode = OPS[r];
      @(negedge clk); rst = 1'b0; #1;
      for (int s = 0; s < 6; s++) begin
        if (s > 0) begin @(negedge clk); #1; end
        sample((s < 3) ? "R3" : TAGS[r], s, EXP[r*6 + s]);
      end
      @(negedge clk); #1;
      chk("R2 wrap to T1", {26'd0, t_state}, 32'h1);
    end

    // R7: halt opcode, fetch unaffected, freeze at T4
    hold_reset();
    opcode = 4'hF;
    @(negedge clk); rst = 1'b0; #1;
    sample("R3 fetch under halt", 0, W_T1);
    @(negedge clk); #1; sample("R3 fetch under halt", 1, W_T2);
    @(negedge clk); #1; sample("R3 fetch under halt", 2, W_T3);
    @(negedge clk); #1; sample("R7 halt T4", 3, W_HALT);
    for (int k = 0; k < 6; k++) begin
      if (k == 2) opcode = 4'h1;
      @(negedge clk); #1;
      sample("R7 frozen", 3, W_HALT);
    end
    hold_reset();
    @(negedge clk); rst = 1'b0; opcode = 4'h0; #1;
    sample("R7 reset clears halt", 0, W_T1);

    // R1: reset taken in the middle of an instruction
    @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk); #1;
    sample("R4 mid run", 4, 13'h0240);
    @(negedge clk); rst = 1'b1; #1;
    check_idle_pins("R1 mid-run reset pins");
    @(negedge clk); #1;
    chk("R1 mid-run reset state", {26'd0, t_state}, 32'h1);
    @(negedge clk); rst = 1'b0; #1;
    sample("R3 after reset", 0, W_T1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule